// File: doc/BRIEF.md
# Processor Operating-Mode Summary Register

This block keeps a compact word that sums up the processor's operating state. It holds its own copies of five architectural sources: the control word (protection-enable and paging), the extended-features word (long-mode-active), the flags word (virtual-8086 flag), and the attribute words of the code and stack segments (privilege level, default-size bit, long-mode bit). From these it derives a summary word. The word holds the mode (Legacy or Long), the submode, the current privilege level, copies of the paging and protection bits, and size codes for the default and alternate operand size, the default and alternate address size, and the stack width. Decode logic can then read mode information without re-deriving it.

Writes arrive on a single write port. Each write carries a select code and a side-effect flag. A side-effect write to the control word or to either segment attribute word stores the word and refreshes the summary in the same edge. The refresh uses the incoming data in place of the stale stored copy. A side-effect write to the summary itself only recomputes it from stored state. A plain write stores its data and leaves the summary alone. A plain write to the summary loads the data verbatim. Any register can be read back through a combinational read port.

Top module: `mode_summary_reg`

## Requirements
- R1: After reset the summary reads 0x0001_5500: Legacy/Real, CPL 0, paging and protection clear, every size code 1. All five stored sources read 0.
- R2: The summary is packed as follows: mode in bit 0 (1 = Long); submode in bits [3:1] (0 Real, 1 Protected, 2 Virtual-8086, 3 Compatibility, 4 64-bit); CPL in [5:4]; paging in bit 6; protection in bit 7; default operand size in [9:8]; alternate operand size in [11:10]; default address size in [13:12]; alternate address size in [15:14]; stack size in [17:16]. Bits above 17 are 0 after a refresh. With long-mode-active (extended word bit 0) set, the mode is Long. The submode is 64-bit when the code-segment long bit (attribute bit 3) is set, otherwise Compatibility.
- R3: With long-mode-active clear, the mode is Legacy. The submode is Real when protection-enable (control bit 0) is 0. It is Virtual-8086 when protection-enable is 1 and the virtual-8086 flag (flags bit 0) is 1. Otherwise it is Protected.
- R4: CPL copies code-segment attribute bits [1:0]. The paging bit copies control bit 1. The protection bit copies control bit 0.
- R5: Size codes are 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. The operand sizes (default/alternate) are 2/1 in the 64-bit submode or when the code-segment default-size bit (attribute bit 2) is set. Otherwise they are 1/2.
- R6: The address sizes (default/alternate) are 3/2 in the 64-bit submode. Otherwise they are 2/1 when the code-segment default-size bit is set, and 1/2 when it is clear.
- R7: The stack size is 3 in the 64-bit submode. Otherwise it is 2 when the stack-segment default-size bit (attribute bit 2) is set, and 1 when it is clear.
- R8: A side-effect write to the control word (select 0), the code attributes (select 3) or the stack attributes (select 4) stores the data. The recomputed summary appears in the next cycle and reflects the written data.
- R9: A side-effect write to the summary (select 5) recomputes it from the stored sources, discards the write data, and changes no source register.
- R10: A plain write stores its data to the selected source without changing the summary. A plain write to select 5 loads the data into the summary unchanged. The read port returns the stored word for selects 0 to 5.
- R11: Writes to the extended word (select 1) or the flags word (select 2) never refresh the summary, even with the side-effect flag set. Writes to selects 6 and 7 change nothing, and reads of those selects return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_side_i | input | 1 | Write carries side effects (refresh) |
| wr_sel_i | input | 3 | Write target: 0 control, 1 extended, 2 flags, 3 code attr, 4 stack attr, 5 summary |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 3 | Read target, same encoding |
| rd_data_o | output | DATA_W | Selected stored word |
| summary_o | output | DATA_W | Current summary word |

## Verification
The hardest situation to reach is a mismatch between the stored sources and the summary. This happens when plain writes change sources without a refresh, or when a raw load puts arbitrary data in the summary. In that state the next refresh must pick the right mix of new write data and stored values. The stimulus draws random selects, side-effect flags and data from a few low bits, so mismatched states build up often. Directed sequences then step through every submode and both default-size settings, so that each size table entry is seen.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam int SEL_W  = 3;
  localparam int SUMM_W = 18;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_EXT   = 3'd1,
    SEL_FLAGS = 3'd2,
    SEL_CSA   = 3'd3,
    SEL_SSA   = 3'd4,
    SEL_SUMM  = 3'd5
  } sel_e;

  localparam int NUM_SRC = 5;

  typedef enum logic [2:0] {
    SUB_REAL   = 3'd0,
    SUB_PROT   = 3'd1,
    SUB_V86    = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_LONG64 = 3'd4
  } submode_e;

  // source bit positions
  localparam int CTRL_PE  = 0;
  localparam int CTRL_PG  = 1;
  localparam int EXT_LMA  = 0;
  localparam int FLG_VM   = 0;
  localparam int ATTR_DSZ = 2;
  localparam int ATTR_LNG = 3;

  typedef struct packed {
    logic [1:0] stack;
    logic [1:0] alt_addr;
    logic [1:0] def_addr;
    logic [1:0] alt_op;
    logic [1:0] def_op;
    logic       prot;
    logic       paging;
    logic [1:0] cpl;
    submode_e   sub;
    logic       mode;
  } summary_t;

  localparam summary_t SUMM_RST = '{stack: 2'd1, alt_addr: 2'd1, def_addr: 2'd1,
                                    alt_op: 2'd1, def_op: 2'd1, prot: 1'b0,
                                    paging: 1'b0, cpl: 2'd0, sub: SUB_REAL,
                                    mode: 1'b0};

endpackage

// File: rtl/msr_state_regs.sv
module msr_state_regs
  import msr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [SEL_W-1:0]         wr_sel_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic [NUM_SRC-1:0][DATA_W-1:0] src_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(i))     q <= wr_data_i;
    end
    assign src_o[i] = q;
  end

  // out-of-range selects touch no source
  a_r11_unused_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i > SEL_W'(NUM_SRC)) |=> $stable(src_o));

endmodule

// File: rtl/msr_summary_calc.sv
module msr_summary_calc
  import msr_pkg::*;
(
  input  logic       lma_i,
  input  logic       pe_i,
  input  logic       pg_i,
  input  logic       vm_i,
  input  logic       cs_long_i,
  input  logic       cs_dsz_i,
  input  logic [1:0] cs_dpl_i,
  input  logic       ss_dsz_i,
  output summary_t   summ_o
);

  submode_e sub;
  logic     is64;

  always_comb begin
    if (lma_i)      sub = cs_long_i ? SUB_LONG64 : SUB_COMPAT;
    else if (!pe_i) sub = SUB_REAL;
    else            sub = vm_i ? SUB_V86 : SUB_PROT;
  end

  assign is64 = (sub == SUB_LONG64);

  always_comb begin
    summ_o        = SUMM_RST;
    summ_o.mode   = lma_i;
    summ_o.sub    = sub;
    summ_o.cpl    = cs_dpl_i;
    summ_o.paging = pg_i;
    summ_o.prot   = pe_i;

    if (is64 || cs_dsz_i) begin
      summ_o.def_op = 2'd2;
      summ_o.alt_op = 2'd1;
    end else begin
      summ_o.def_op = 2'd1;
      summ_o.alt_op = 2'd2;
    end

    if (is64) begin
      summ_o.def_addr = 2'd3;
      summ_o.alt_addr = 2'd2;
    end else if (cs_dsz_i) begin
      summ_o.def_addr = 2'd2;
      summ_o.alt_addr = 2'd1;
    end else begin
      summ_o.def_addr = 2'd1;
      summ_o.alt_addr = 2'd2;
    end

    if (is64)          summ_o.stack = 2'd3;
    else if (ss_dsz_i) summ_o.stack = 2'd2;
    else               summ_o.stack = 2'd1;
  end

endmodule

// File: rtl/msr_summary_reg.sv
module msr_summary_reg
  import msr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              refresh_i,
  input  logic              load_i,
  input  summary_t          calc_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] q_o
);

  localparam int PAD_W = DATA_W - SUMM_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= {{PAD_W{1'b0}}, SUMM_RST};
    else if (refresh_i) q_o <= {{PAD_W{1'b0}}, calc_i};
    else if (load_i)    q_o <= load_data_i;
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refresh_i || load_i) |=> $stable(q_o));

  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(load_data_i));

endmodule

// File: rtl/mode_summary_reg.sv
module mode_summary_reg
  import msr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_side_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] summary_o
);

  logic [NUM_SRC-1:0][DATA_W-1:0] src;
  logic [DATA_W-1:0] ctrl_eff, cs_eff, ss_eff;
  logic              refresh, load;
  summary_t          calc;

  msr_state_regs #(.DATA_W(DATA_W)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .src_o     (src)
  );

  // incoming data replaces the stale copy during a refresh
  assign ctrl_eff = (wr_en_i && wr_sel_i == SEL_CTRL) ? wr_data_i : src[SEL_CTRL];
  assign cs_eff   = (wr_en_i && wr_sel_i == SEL_CSA)  ? wr_data_i : src[SEL_CSA];
  assign ss_eff   = (wr_en_i && wr_sel_i == SEL_SSA)  ? wr_data_i : src[SEL_SSA];

  always_comb begin
    refresh = 1'b0;
    if (wr_en_i && wr_side_i) begin
      unique case (wr_sel_i)
        SEL_CTRL, SEL_CSA, SEL_SSA, SEL_SUMM: refresh = 1'b1;
        default:                              refresh = 1'b0;
      endcase
    end
  end

  assign load = wr_en_i && !wr_side_i && (wr_sel_i == SEL_SUMM);

  msr_summary_calc u_calc (
    .lma_i     (src[SEL_EXT][EXT_LMA]),
    .pe_i      (ctrl_eff[CTRL_PE]),
    .pg_i      (ctrl_eff[CTRL_PG]),
    .vm_i      (src[SEL_FLAGS][FLG_VM]),
    .cs_long_i (cs_eff[ATTR_LNG]),
    .cs_dsz_i  (cs_eff[ATTR_DSZ]),
    .cs_dpl_i  (cs_eff[1:0]),
    .ss_dsz_i  (ss_eff[ATTR_DSZ]),
    .summ_o    (calc)
  );

  msr_summary_reg #(.DATA_W(DATA_W)) u_summ (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .refresh_i   (refresh),
    .load_i      (load),
    .calc_i      (calc),
    .load_data_i (wr_data_i),
    .q_o         (summary_o)
  );

  always_comb begin
    if (rd_sel_i == SEL_SUMM)               rd_data_o = summary_o;
    else if (rd_sel_i < 3'(NUM_SRC))        rd_data_o = src[rd_sel_i];
    else                                    rd_data_o = '0;
  end

  a_r8_ctrl_real: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_side_i && wr_sel_i == SEL_CTRL && !wr_data_i[CTRL_PE]
     && !src[SEL_EXT][EXT_LMA]) |=> (summary_o[3:0] == 4'd0 && !summary_o[7]));

  a_r5_op_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> (summary_o[9:8] != summary_o[11:10]));

  a_r7_stack_nz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> (summary_o[17:16] != 2'd0));

  a_r11_no_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_sel_i == SEL_EXT || wr_sel_i == SEL_FLAGS)) |=> $stable(summary_o));

  a_r9_src_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_SUMM) |=> $stable(src));

endmodule

// File: tb/mode_summary_reg_tb.sv
module mode_summary_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_side = 1'b0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, summ;

  always #10 clk = ~clk;

  mode_summary_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_side_i(wr_side),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .summary_o(summ)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_reg [0:5];

  function automatic logic [31:0] model(input logic [31:0] ext, ctrl, flg, cs, ss);
    logic [2:0] sub; logic is64; logic [1:0] dop, aop, dad, aad, stk;
    if (ext[0]) sub = cs[3] ? 3'd4 : 3'd3;
    else if (!ctrl[0]) sub = 3'd0;
    else sub = flg[0] ? 3'd2 : 3'd1;
    is64 = (sub == 3'd4);
    dop = (is64 || cs[2]) ? 2'd2 : 2'd1;
    aop = 2'd3 - dop;
    dad = is64 ? 2'd3 : (cs[2] ? 2'd2 : 2'd1);
    aad = is64 ? 2'd2 : (cs[2] ? 2'd1 : 2'd2);
    stk = is64 ? 2'd3 : (ss[2] ? 2'd2 : 2'd1);
    return {14'd0, stk, aad, dad, aop, dop, ctrl[0], ctrl[1], cs[1:0], sub, ext[0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input string tag, input logic [2:0] sel, input logic se,
                    input logic [31:0] d);
    logic [31:0] src [0:5];
    for (int k = 0; k < 6; k++) src[k] = m_reg[k];
    @(negedge clk);
    wr_en = 1'b1; wr_side = se; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel <= 3'd4) m_reg[sel] = d;
    if (se && (sel == 3'd0 || sel == 3'd3 || sel == 3'd4 || sel == 3'd5))
      m_reg[5] = model(m_reg[1], m_reg[0], m_reg[2], m_reg[3], m_reg[4]);
    else if (!se && sel == 3'd5)
      m_reg[5] = d;
    chk(tag, summ, m_reg[5]);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] sel);
    rd_sel = sel;
    #1;
    chk(tag, rd_data, (sel <= 3'd5) ? m_reg[sel] : 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 5; k++) m_reg[k] = '0;
    m_reg[5] = 32'h0001_5500;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", summ, 32'h0001_5500);
    for (int k = 0; k < 8; k++) rd_chk("R1", 3'(k));

    // legacy submodes
    wr("R3", 3'd0, 1'b1, 32'h1);             // protected
    wr("R4", 3'd0, 1'b1, 32'h3);             // paging + prot
    wr("R11", 3'd2, 1'b1, 32'h1);            // vm set, no refresh
    wr("R3", 3'd0, 1'b1, 32'h1);             // v86
    wr("R4", 3'd3, 1'b1, 32'h2);             // cpl 2
    wr("R5", 3'd3, 1'b1, 32'h4);             // cs default-size
    wr("R6", 3'd3, 1'b1, 32'h7);
    wr("R7", 3'd4, 1'b1, 32'h4);             // ss default-size
    wr("R3", 3'd0, 1'b1, 32'h0);             // real
    // long modes
    wr("R11", 3'd1, 1'b1, 32'h1);            // lma, no refresh
    wr("R9", 3'd5, 1'b1, 32'hFFFF_FFFF);     // recompute, data dropped
    wr("R2", 3'd3, 1'b1, 32'h8);             // 64-bit
    wr("R6", 3'd4, 1'b1, 32'h0);
    wr("R2", 3'd3, 1'b1, 32'h0);             // compat
    wr("R5", 3'd3, 1'b1, 32'h4);
    wr("R10", 3'd5, 1'b0, 32'hDEAD_BEEF);    // raw load
    wr("R10", 3'd0, 1'b0, 32'h1);            // plain, summary kept
    rd_chk("R10", 3'd0);
    wr("R11", 3'd6, 1'b1, 32'hFFFF_FFFF);
    wr("R11", 3'd7, 1'b0, 32'hFFFF_FFFF);
    rd_chk("R11", 3'd6);
    wr("R8", 3'd0, 1'b1, 32'h3);
    rd_chk("R8", 3'd0);

    for (int i = 0; i < 600; i++) begin
      logic [2:0] s; logic e; logic [31:0] d; string t;
      s = 3'($urandom % 8);
      e = 1'($urandom % 2);
      d = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hF);
      if (e && (s == 3'd0 || s == 3'd3 || s == 3'd4)) t = "R8";
      else if (e && s == 3'd5) t = "R9";
      else if (s >= 3'd6 || s == 3'd1 || s == 3'd2) t = "R11";
      else t = "R10";
      wr(t, s, e, d);
      rd_chk("R10", 3'($urandom % 8));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule